// File: doc/BRIEF.md
# Single-Line Quad-Word Read Buffer

This block sits on one bus port in front of memory and holds a single cached line: the four-word aligned block (a quad word) most recently fetched through that port, together with its tag and a valid flag. A read that falls inside the held quad word is answered from the line one cycle after it is accepted, and no memory traffic is generated. A read outside it is a miss. On a miss the block issues a four-beat read burst for the aligned quad word, stores every returned beat, and then answers with the requested word.

Writes arriving on the same port are not carried out by this block. Their only effect is to drop the line when the write address lies inside the held quad word. Writes on other ports never reach this block, so it provides no coherency between ports. A level enable input turns the buffer off. While it is low, the line is kept invalid and every read goes to memory.

The port handles one request at a time. While a fill is in progress the block lowers its ready signal and holds new requests off.

Top module: `qword_rdbuf`

## Requirements
- R1: During and after reset, the line is invalid, `rsp_valid` and `mem_req` are 0, and `req_ready` is 1.
- R2: A read accepted while enabled whose tag (address bits [AW-1:4]) matches a valid line gives `rsp_valid`=1 in the next cycle. `rsp_data` is the stored word that address bits [3:2] select, and no `mem_req` is raised.
- R3: A read that misses raises `mem_req` for exactly one cycle, in the cycle after acceptance. During that cycle, `mem_addr` holds the read address with bits [3:0] forced to zero.
- R4: Burst beats are taken in ascending word order 0 to 3. In the cycle after the fourth beat, `rsp_valid` is 1 and `rsp_data` is the beat whose index equals address bits [3:2] of the missed read.
- R5: After a fill completes while enabled, later reads anywhere in that quad word are hits and cause no memory access.
- R6: An accepted write whose address bits [AW-1:4] equal the line tag invalidates the line, so the next read of that quad word misses. A write to any other quad word leaves the line valid.
- R7: While `enable` is 0, the line is cleared every cycle. A fill that completes while disabled does not make the line valid, so reads issued after re-enabling miss.
- R8: `req_ready` is 0 from the cycle after a miss is accepted until the cycle after the fourth beat. Requests are accepted only when `req_ready` is 1.
- R9: An accepted write gives no `rsp_valid` and no `mem_req` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Buffer enable; low keeps the line invalid |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | AW | Byte address of the request |
| req_ready | output | 1 | Request accepted in this cycle when high with `req_valid` |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | DW | Read data word |
| mem_req | output | 1 | One-cycle burst request to memory |
| mem_addr | output | AW | Aligned quad-word address of the burst |
| mem_beat_valid | input | 1 | Burst beat present |
| mem_beat_data | input | DW | Burst beat data |

## Verification
Each result has a fixed latency. A hit answers one cycle after acceptance. A miss raises the burst request one cycle after acceptance. The fill answer and the return of ready come one cycle after the fourth beat. A write produces nothing in the cycle after it. A behavioural reference model in the bench advances on each rising edge from the same inputs and predicts ready, the burst request and address, and the response. The model is compared with the design on every falling edge, so every comparison falls in the exact cycle in which a result is due. Counts of burst requests taken around hit, invalidation and disable sequences show whether memory was touched at all.

// File: rtl/rdbuf_pkg.sv
package rdbuf_pkg;

    // Words held by the line (one quad word).
    localparam int RB_BEATS  = 4;
    localparam int RB_WSEL_W = $clog2(RB_BEATS);

    typedef enum logic [1:0] {
        RB_IDLE  = 2'd0,
        RB_ISSUE = 2'd1,
        RB_FILL  = 2'd2
    } rb_state_e;

    // Write command into line storage during a fill.
    typedef struct packed {
        logic                 we;
        logic [RB_WSEL_W-1:0] idx;
    } rb_fill_t;

    // Line-status update from the controller.
    typedef struct packed {
        logic inval;
        logic commit;
    } rb_upd_t;

endpackage

// File: rtl/rdbuf_line.sv
module rdbuf_line
    import rdbuf_pkg::*;
#(
    parameter int DW    = 32,
    parameter int TAG_W = 28
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  rb_upd_t              upd,
    input  logic [TAG_W-1:0]     commit_tag,
    input  rb_fill_t             fill,
    input  logic [DW-1:0]        fill_data,
    input  logic [TAG_W-1:0]     look_tag,
    input  logic [RB_WSEL_W-1:0] look_idx,
    output logic                 valid,
    output logic                 match,
    output logic [DW-1:0]        look_word
);

    logic [TAG_W-1:0] tag_q;
    logic [DW-1:0]    words [RB_BEATS];

    genvar gi;
    generate
        for (gi = 0; gi < RB_BEATS; gi++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst) begin
                    words[gi] <= '0;
                end else if (fill.we && (fill.idx == RB_WSEL_W'(gi))) begin
                    words[gi] <= fill_data;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            tag_q <= '0;
        end else if (clr) begin
            valid <= 1'b0;
        end else if (upd.inval) begin
            valid <= 1'b0;
        end else if (upd.commit) begin
            valid <= 1'b1;
            tag_q <= commit_tag;
        end
    end

    assign match     = (tag_q == look_tag);
    assign look_word = words[look_idx];

endmodule

// File: rtl/rdbuf_ctrl.sv
module rdbuf_ctrl
    import rdbuf_pkg::*;
#(
    parameter int DW    = 32,
    parameter int TAG_W = 28
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [TAG_W-1:0]     req_tag,
    input  logic [RB_WSEL_W-1:0] req_wsel,
    input  logic                 hit,
    input  logic                 match,
    input  logic [DW-1:0]        hit_word,
    input  logic                 beat_valid,
    input  logic [DW-1:0]        beat_data,
    output logic                 req_ready,
    output logic                 mem_req,
    output logic [TAG_W-1:0]     pend_tag,
    output rb_fill_t             fill,
    output rb_upd_t              upd,
    output logic                 rsp_valid,
    output logic [DW-1:0]        rsp_data
);

    localparam logic [RB_WSEL_W-1:0] LAST_BEAT = RB_WSEL_W'(RB_BEATS - 1);

    rb_state_e            state;
    logic [RB_WSEL_W-1:0] beat_cnt;
    logic [RB_WSEL_W-1:0] pend_wsel;
    logic                 last_beat;

    assign req_ready = (state == RB_IDLE);
    assign mem_req   = (state == RB_ISSUE);
    assign last_beat = (state == RB_FILL) && beat_valid && (beat_cnt == LAST_BEAT);

    always_comb begin
        fill.we    = (state == RB_FILL) && beat_valid;
        fill.idx   = beat_cnt;
        upd.commit = last_beat && enable;
        upd.inval  = req_ready && req_valid && req_write && match;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RB_IDLE;
            beat_cnt  <= '0;
            pend_tag  <= '0;
            pend_wsel <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                RB_IDLE: begin
                    if (req_valid && !req_write) begin
                        if (hit) begin
                            rsp_valid <= 1'b1;
                            rsp_data  <= hit_word;
                        end else begin
                            pend_tag  <= req_tag;
                            pend_wsel <= req_wsel;
                            beat_cnt  <= '0;
                            state     <= RB_ISSUE;
                        end
                    end
                end
                RB_ISSUE: begin
                    state <= RB_FILL;
                end
                RB_FILL: begin
                    if (beat_valid) begin
                        beat_cnt <= beat_cnt + 1'b1;
                        if (beat_cnt == pend_wsel) begin
                            rsp_data <= beat_data;
                        end
                        if (beat_cnt == LAST_BEAT) begin
                            rsp_valid <= 1'b1;
                            state     <= RB_IDLE;
                        end
                    end
                end
                default: state <= RB_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/qword_rdbuf.sv
module qword_rdbuf
    import rdbuf_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_beat_valid,
    input  logic [DW-1:0] mem_beat_data
);

    localparam int BYTE_W = $clog2(DW / 8);
    localparam int OFS_W  = BYTE_W + RB_WSEL_W;
    localparam int TAG_W  = AW - OFS_W;

    logic [TAG_W-1:0]     req_tag;
    logic [RB_WSEL_W-1:0] req_wsel;
    logic [TAG_W-1:0]     pend_tag;
    logic                 line_valid;
    logic                 line_match;
    logic                 hit;
    logic [DW-1:0]        line_word;
    rb_fill_t             fill;
    rb_upd_t              upd;

    assign req_tag  = req_addr[AW-1:OFS_W];
    assign req_wsel = req_addr[OFS_W-1:BYTE_W];
    assign hit      = enable && line_valid && line_match;
    assign mem_addr = {pend_tag, {OFS_W{1'b0}}};

    rdbuf_line #(.DW(DW), .TAG_W(TAG_W)) u_line (
        .clk        (clk),
        .rst        (rst),
        .clr        (!enable),
        .upd        (upd),
        .commit_tag (pend_tag),
        .fill       (fill),
        .fill_data  (mem_beat_data),
        .look_tag   (req_tag),
        .look_idx   (req_wsel),
        .valid      (line_valid),
        .match      (line_match),
        .look_word  (line_word)
    );

    rdbuf_ctrl #(.DW(DW), .TAG_W(TAG_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_tag    (req_tag),
        .req_wsel   (req_wsel),
        .hit        (hit),
        .match      (line_match),
        .hit_word   (line_word),
        .beat_valid (mem_beat_valid),
        .beat_data  (mem_beat_data),
        .req_ready  (req_ready),
        .mem_req    (mem_req),
        .pend_tag   (pend_tag),
        .fill       (fill),
        .upd        (upd),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data)
    );

endmodule

// File: rtl/rdbuf_chk.sv
module rdbuf_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_write,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!rsp_valid && !mem_req && req_ready));

    // R3
    mreq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R3
    maddr_align_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[3:0] == 4'd0));

    // R8
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready);

    // R2
    rd_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_write) |=> (rsp_valid != mem_req));

    // R9
    write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write) |=> (!rsp_valid && !mem_req));

endmodule

bind qword_rdbuf rdbuf_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr)
);

// File: tb/sim_qword_rdbuf.sv
`timescale 1ns/1ps
module sim_qword_rdbuf;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_beat_valid = 1'b0;
    logic [31:0] mem_beat_data = '0;

    int checks = 0;
    int fails  = 0;
    int mreq_cnt = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    qword_rdbuf u0 (
        .clk(clk), .rst(rst), .enable(enable),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_beat_valid(mem_beat_valid), .mem_beat_data(mem_beat_data)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h3C00_0000;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Memory responder: four ascending beats after a burst request.
    int          left = 0;
    logic [31:0] base = '0;
    int          bidx = 0;
    always @(negedge clk) begin
        if (left > 0) begin
            mem_beat_valid <= 1'b1;
            mem_beat_data  <= mem_word(base + 32'(bidx * 4));
            bidx++;
            left--;
        end else begin
            mem_beat_valid <= 1'b0;
        end
        if (!rst && mem_req) begin
            left = 4; bidx = 0; base = mem_addr;
            mreq_cnt++;
        end
    end

    // Behavioural reference model.
    bit          m_valid, m_busy, e_rv, e_mreq;
    logic [27:0] m_tag;
    logic [31:0] m_addr, e_rd;
    logic [31:0] m_line [4];
    int          m_cnt;

    always @(posedge clk) begin
        if (rst) begin
            m_valid <= 0; m_busy <= 0; e_rv <= 0; e_mreq <= 0;
            m_tag <= '0; m_cnt <= 0; m_addr <= '0; e_rd <= '0;
        end else begin
            e_rv <= 0; e_mreq <= 0;
            if (!m_busy && req_valid) begin
                if (!req_write) begin
                    if (enable && m_valid && m_tag == req_addr[31:4]) begin
                        e_rv <= 1; e_rd <= m_line[req_addr[3:2]];
                    end else begin
                        m_busy <= 1; e_mreq <= 1; m_cnt <= 0; m_addr <= req_addr;
                    end
                end else if (m_tag == req_addr[31:4]) begin
                    m_valid <= 0;
                end
            end
            if (m_busy && !e_mreq && mem_beat_valid) begin
                m_line[m_cnt] <= mem_beat_data;
                if (m_cnt == int'(m_addr[3:2])) e_rd <= mem_beat_data;
                m_cnt <= m_cnt + 1;
                if (m_cnt == 3) begin
                    m_busy <= 0; e_rv <= 1;
                    if (enable) begin m_valid <= 1; m_tag <= m_addr[31:4]; end
                end
            end
            if (!enable) m_valid <= 0;
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            check("R8 req_ready", 32'(req_ready), 32'(!m_busy));
            check("R3 mem_req", 32'(mem_req), 32'(e_mreq));
            if (e_mreq) check("R3 mem_addr", mem_addr, {m_addr[31:4], 4'h0});
            check("R2 rsp_valid", 32'(rsp_valid), 32'(e_rv));
            if (e_rv) check("R4 rsp_data", rsp_data, e_rd);
        end
    end

    task automatic issue(input bit wr, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    int snap;
    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 rsp_valid", 32'(rsp_valid), 0);
        check("R1 mem_req", 32'(mem_req), 0);
        check("R1 req_ready", 32'(req_ready), 1);
        @(negedge clk); rst = 1'b0; enable = 1'b1;

        // R3 R4 miss and fill, word 1
        issue(0, 32'h0000_0104); settle();
        check("R3 burst count", 32'(mreq_cnt), 1);

        // R5 R2 hits in the filled quad word, one back-to-back
        snap = mreq_cnt;
        issue(0, 32'h0000_0100);
        issue(0, 32'h0000_010C);
        @(negedge clk); req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h108;
        @(negedge clk); req_addr = 32'h104;
        @(negedge clk); req_valid = 1'b0;
        settle();
        check("R5 hits cause no burst", 32'(mreq_cnt), 32'(snap));

        // R4 miss on word 3 of a new quad word
        issue(0, 32'h0000_020C); settle();
        check("R4 new fill burst", 32'(mreq_cnt), 32'(snap + 1));

        // R6 R9 write elsewhere keeps the line
        snap = mreq_cnt;
        issue(1, 32'h0000_0300); settle();
        issue(0, 32'h0000_0204); settle();
        check("R6 foreign write keeps line", 32'(mreq_cnt), 32'(snap));

        // R6 same-quad write invalidates
        issue(1, 32'h0000_0208); settle();
        check("R9 write makes no burst", 32'(mreq_cnt), 32'(snap));
        issue(0, 32'h0000_0200); settle();
        check("R6 read after invalidate misses", 32'(mreq_cnt), 32'(snap + 1));

        // R7 disable clears the line
        snap = mreq_cnt;
        @(negedge clk); enable = 1'b0;
        repeat (2) @(negedge clk); enable = 1'b1;
        issue(0, 32'h0000_0204); settle();
        check("R7 read after disable misses", 32'(mreq_cnt), 32'(snap + 1));

        // R7 fill while disabled is not retained
        @(negedge clk); enable = 1'b0;
        issue(0, 32'h0000_0408); settle();
        @(negedge clk); enable = 1'b1;
        issue(0, 32'h0000_0404); settle();
        check("R7 disabled fill not kept", 32'(mreq_cnt), 32'(snap + 3));
        issue(0, 32'h0000_0400); settle();
        check("R5 enabled fill kept", 32'(mreq_cnt), 32'(snap + 3));

        finish_run();
    end

endmodule